// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block gathers a vector of interrupt sources into one shared, latched pending set and presents it to two independent consumer banks: a normal-priority bank and a fast bank. Each bank keeps its own enable set, forms its own masked pending set, and reports the lowest-numbered pending enabled source. Each bank also drives a single request line to the processor.

A source is captured on its rising edge. It stays pending until software writes a bitmap that acknowledges it. Enables are never written directly. One word address sets enable bits, a second word address clears them, and both addresses read back the current enable set. This lets two software agents change separate enable bits without a read-modify-write. The register window is word addressed and reads are combinational. The fast bank uses the same register layout as the normal bank, displaced by byte offset 0x100 (word offset 0x40).

Top module: `dual_bank_intc`

## Requirements
- R1: After reset, the pending set, both enable sets and both request lines are zero, and every register reads zero.
- R2: A low-to-high transition on source n sets pending bit n on the next clock edge. A source that is held high does not set the bit again once it has been acknowledged.
- R3: Writing a bitmap to word 1 of either bank (byte 0x04 or 0x104) clears those pending bits. Pending bits not named in the bitmap keep their value. Reading word 1 of either bank returns the shared pending set.
- R4: When a new rising edge on source n arrives in the same cycle as an acknowledge of bit n, bit n remains set.
- R5: Writing a bitmap to word 2 of a bank (byte 0x08 / 0x108) sets those bits of that bank's enable set. Reading word 2 returns that enable set.
- R6: Writing a bitmap to word 3 of a bank (byte 0x0C / 0x10C) clears those enable bits. Reading word 3 returns the same value as word 2.
- R7: Reading word 0 of a bank (byte 0x00 / 0x100) returns the pending set ANDed with that bank's enable set.
- R8: Word 4 of a bank (byte 0x10 / 0x110) returns, in bits [log2(N)-1:0], the index of the lowest set bit of the masked set, and returns bit 31 as a valid flag. When the masked set is empty, the word reads zero.
- R9: Each bank's request line (irq_o for the normal bank, fiq_o for the fast bank) equals the OR of that bank's masked set, delayed by one clock.
- R10: The two banks hold independent enable sets and share one pending set, so an acknowledge through either bank clears the shared bits.
- R11: Reads of any other word in the window return zero, and writes to such words change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Interrupt source levels |
| reg_wr_i | input | 1 | Write strobe for the register window |
| reg_addr_i | input | ADDR_W | Word address; the top bit selects the fast bank |
| reg_wdata_i | input | DATA_W | Write data bitmap |
| reg_rdata_o | output | DATA_W | Combinational read data for reg_addr_i |
| irq_o | output | 1 | Normal bank request line |
| fiq_o | output | 1 | Fast bank request line |

## Verification
The bench builds the block with its full default width: 32 sources, 32-bit data and a 7-bit word address. Every source index is therefore swept individually, for capture, visibility through both banks, and acknowledge alternating between the banks. A second sweep raises every source at or above index i for each i. It computes the expected lowest index for a fully enabled normal bank and for a fast bank enabled only in the upper half, which exercises the priority result at both ends and across the half boundary. Directed cases cover the same-cycle edge/acknowledge race, a source held high, the one-cycle request delay, and aliased or unmapped words.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NBANK = 2;

  typedef enum logic [2:0] {
    SEL_MASKED = 3'd0,
    SEL_RAW    = 3'd1,
    SEL_EN     = 3'd2,
    SEL_DIS    = 3'd3,
    SEL_NUM    = 3'd4
  } intc_sel_e;
endpackage

// File: rtl/intc_edge_capture.sv
module intc_edge_capture #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] ack_i,
  output logic [NSRC-1:0] raw_o
);
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] raw_q;
  logic [NSRC-1:0] edge_w;

  assign edge_w = src_i & ~src_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[i] <= 1'b0;
        raw_q[i] <= 1'b0;
      end else begin
        src_q[i] <= src_i[i];
        // a fresh edge outranks an acknowledge of the same bit
        raw_q[i] <= edge_w[i] | (raw_q[i] & ~ack_i[i]);
      end
    end
  end

  assign raw_o = raw_q;

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_w) |=> ((raw_q & $past(edge_w)) == $past(edge_w))); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_i) |=> ((raw_q & $past(ack_i & ~edge_w)) == '0)); // R3
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_i & edge_w)) |=> ((raw_q & $past(ack_i & edge_w)) == $past(ack_i & edge_w))); // R4
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int NSRC  = 32,
  parameter int NUM_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  raw_i,
  input  logic [NSRC-1:0]  set_i,
  input  logic [NSRC-1:0]  clr_i,
  output logic [NSRC-1:0]  en_o,
  output logic [NSRC-1:0]  masked_o,
  output logic [NUM_W-1:0] num_o,
  output logic             num_valid_o,
  output logic             line_o
);
  logic [NSRC-1:0]  en_q;
  logic [NSRC-1:0]  masked_w;
  logic [NUM_W-1:0] num_w;
  logic             any_w;
  logic             line_q;

  function automatic logic [NUM_W-1:0] lowest_set(input logic [NSRC-1:0] v);
    logic [NUM_W-1:0] idx;
    idx = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (v[k]) idx = NUM_W'(k);
    end
    return idx;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= (en_q | set_i) & ~clr_i;
  end

  assign masked_w = raw_i & en_q;
  assign any_w    = |masked_w;
  assign num_w    = any_w ? lowest_set(masked_w) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= any_w;
  end

  assign en_o        = en_q;
  assign masked_o    = masked_w;
  assign num_o       = num_w;
  assign num_valid_o = any_w;
  assign line_o      = line_q;

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((en_q & $past(set_i)) == $past(set_i))); // R5
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((en_q & $past(clr_i)) == '0)); // R6
  AST_NUM_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    any_w |-> (masked_w[num_w] && ((masked_w & ((NSRC'(1) << num_w) - NSRC'(1))) == '0))); // R8
  AST_LINE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (line_q == $past(|(raw_i & en_q)))); // R9
endmodule

// File: rtl/intc_regif.sv
module intc_regif
  import intc_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int NUM_W  = $clog2(NSRC),
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic                        wr_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [NSRC-1:0]             raw_i,
  input  logic [NBANK-1:0][NSRC-1:0]  en_i,
  input  logic [NBANK-1:0][NSRC-1:0]  masked_i,
  input  logic [NBANK-1:0][NUM_W-1:0] num_i,
  input  logic [NBANK-1:0]            valid_i,
  output logic [NBANK-1:0][NSRC-1:0]  set_o,
  output logic [NBANK-1:0][NSRC-1:0]  clr_o,
  output logic [NSRC-1:0]             ack_o,
  output logic [DATA_W-1:0]           rdata_o
);
  localparam int GAP_HI = ADDR_W - 2;

  logic            bank_w;
  logic            hit_w;
  logic [2:0]      sel_w;
  logic [NSRC-1:0] bitmap_w;

  assign bank_w   = addr_i[ADDR_W-1];
  assign hit_w    = (addr_i[GAP_HI:3] == '0);
  assign sel_w    = addr_i[2:0];
  assign bitmap_w = wdata_i[NSRC-1:0];

  assign ack_o = (wr_i && hit_w && sel_w == SEL_RAW) ? bitmap_w : '0;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank_wr
    logic mine;
    assign mine     = wr_i && hit_w && (bank_w == 1'(b));
    assign set_o[b] = (mine && sel_w == SEL_EN)  ? bitmap_w : '0;
    assign clr_o[b] = (mine && sel_w == SEL_DIS) ? bitmap_w : '0;
  end

  always_comb begin
    rdata_o = '0;
    if (hit_w) begin
      case (sel_w)
        SEL_MASKED:     rdata_o = DATA_W'(masked_i[bank_w]);
        SEL_RAW:        rdata_o = DATA_W'(raw_i);
        SEL_EN, SEL_DIS: rdata_o = DATA_W'(en_i[bank_w]);
        SEL_NUM: begin
          rdata_o[NUM_W-1:0] = num_i[bank_w];
          rdata_o[DATA_W-1]  = valid_i[bank_w];
        end
        default:        rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int NUM_W = $clog2(NSRC);

  logic [NSRC-1:0]             raw_w;
  logic [NSRC-1:0]             ack_w;
  logic [NBANK-1:0][NSRC-1:0]  set_w;
  logic [NBANK-1:0][NSRC-1:0]  clr_w;
  logic [NBANK-1:0][NSRC-1:0]  en_w;
  logic [NBANK-1:0][NSRC-1:0]  masked_w;
  logic [NBANK-1:0][NUM_W-1:0] num_w;
  logic [NBANK-1:0]            valid_w;
  logic [NBANK-1:0]            line_w;

  intc_edge_capture #(.NSRC(NSRC)) u_capture (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (src_i),
    .ack_i (ack_w),
    .raw_o (raw_w)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    intc_bank #(.NSRC(NSRC), .NUM_W(NUM_W)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .raw_i       (raw_w),
      .set_i       (set_w[b]),
      .clr_i       (clr_w[b]),
      .en_o        (en_w[b]),
      .masked_o    (masked_w[b]),
      .num_o       (num_w[b]),
      .num_valid_o (valid_w[b]),
      .line_o      (line_w[b])
    );
  end

  intc_regif #(.NSRC(NSRC), .NUM_W(NUM_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .raw_i    (raw_w),
    .en_i     (en_w),
    .masked_i (masked_w),
    .num_i    (num_w),
    .valid_i  (valid_w),
    .set_o    (set_w),
    .clr_o    (clr_w),
    .ack_o    (ack_w),
    .rdata_o  (reg_rdata_o)
  );

  assign irq_o = line_w[0];
  assign fiq_o = line_w[1];

  AST_SHARED_RAW_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i[ADDR_W-2:0] == (ADDR_W-1)'(1)) |-> (ack_w == reg_wdata_i[NSRC-1:0])); // R10
endmodule

// File: tb/dual_bank_intc_tb.sv
`timescale 1ns/1ps
module dual_bank_intc_tb;
  localparam int NSRC = 32;
  localparam int AW   = 7;
  localparam int DW   = 32;
  localparam logic [AW-1:0] FIQ = 7'h40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   src = '0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq, fiq;
  int            n_chk = 0;
  int            n_bad = 0;
  logic [31:0]   got;

  always #2.5 clk = ~clk;

  dual_bank_intc #(.NSRC(NSRC), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(input logic [31:0] m);
    @(negedge clk); src = src | m;
    @(negedge clk); src = src & ~m;
  endtask

  function automatic logic [31:0] num_word(input logic [31:0] masked);
    for (int k = 0; k < 32; k++)
      if (masked[k]) return 32'h8000_0000 | k;
    return 32'h0;
  endfunction

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int w = 0; w < 5; w++) begin
      rd_reg(AW'(w), got);       check("R1 irq word", got, 0);
      rd_reg(FIQ | AW'(w), got); check("R1 fiq word", got, 0);
    end
    check("R1 irq line", {31'b0, irq}, 0);
    check("R1 fiq line", {31'b0, fiq}, 0);

    // R2 R3 R10: per-source sweep, acknowledge alternating between banks
    for (int i = 0; i < 32; i++) begin
      pulse(32'h1 << i);
      rd_reg(7'h01, got);       check("R2 raw after edge", got, 32'h1 << i);
      rd_reg(FIQ | 7'h01, got); check("R10 shared raw via fiq", got, 32'h1 << i);
      wr_reg((i % 2 == 1) ? (FIQ | 7'h01) : 7'h01, 32'h1 << i);
      rd_reg(7'h01, got);       check("R3 raw after ack", got, 0);
    end

    // R3 partial ack keeps others
    pulse(32'h0000_00F0);
    wr_reg(7'h01, 32'h0000_0030);
    rd_reg(7'h01, got); check("R3 partial ack", got, 32'h0000_00C0);
    wr_reg(7'h01, 32'hFFFF_FFFF);

    // R2 level held: no re-capture after ack
    @(negedge clk); src[5] = 1'b1;
    wr_reg(7'h01, 32'h20);
    repeat (3) @(negedge clk);
    rd_reg(7'h01, got); check("R2 held level not recaptured", got, 0);
    @(negedge clk); src[5] = 1'b0;

    // R4 edge wins over same-cycle ack; bit 9 without edge clears
    pulse(32'h0000_0208);
    rd_reg(7'h01, got); check("R4 setup raw", got, 32'h0000_0208);
    @(negedge clk); src[3] = 1'b1; wr = 1'b1; addr = 7'h01; wdata = 32'h0000_0208;
    @(negedge clk); wr = 1'b0; src[3] = 1'b0;
    rd_reg(7'h01, got); check("R4 edge beats ack", got, 32'h0000_0008);
    wr_reg(7'h01, 32'hFFFF_FFFF);

    // R5 R6 enable set/clear with mirror, per bank
    wr_reg(7'h02, 32'h0000_F00F);
    wr_reg(7'h02, 32'h00F0_0000);
    rd_reg(7'h02, got); check("R5 irq enable set", got, 32'h00F0_F00F);
    wr_reg(7'h03, 32'h0000_300C);
    rd_reg(7'h03, got); check("R6 irq disable mirror", got, 32'h00F0_C003);
    rd_reg(7'h02, got); check("R6 irq enable after clear", got, 32'h00F0_C003);
    rd_reg(FIQ | 7'h02, got); check("R10 fiq enable independent", got, 0);
    wr_reg(FIQ | 7'h02, 32'h0000_0003);
    rd_reg(FIQ | 7'h03, got); check("R5 fiq enable mirror", got, 32'h0000_0003);

    // R11 unmapped / aliased words ignored
    wr_reg(7'h05, 32'hFFFF_FFFF);
    wr_reg(7'h0A, 32'hFFFF_FFFF);
    wr_reg(7'h0B, 32'hFFFF_FFFF);
    rd_reg(7'h02, got); check("R11 enable untouched", got, 32'h00F0_C003);
    rd_reg(FIQ | 7'h02, got); check("R11 fiq enable untouched", got, 32'h0000_0003);
    rd_reg(7'h05, got); check("R11 unmapped reads zero", got, 0);
    rd_reg(7'h0A, got); check("R11 alias reads zero", got, 0);

    // R7 R9 masked status and delayed line
    @(negedge clk); src = 32'h0040_0002;
    @(negedge clk); src = 32'h0;
    #1 check("R9 irq not yet", {31'b0, irq}, 0);
    @(negedge clk);
    check("R9 irq after one cycle", {31'b0, irq}, 1);
    check("R9 fiq line", {31'b0, fiq}, 1);
    rd_reg(7'h00, got);       check("R7 irq masked", got, 32'h0040_0002);
    rd_reg(FIQ | 7'h00, got); check("R7 fiq masked", got, 32'h0000_0002);
    rd_reg(7'h04, got);       check("R8 irq number", got, 32'h8000_0001);
    wr_reg(FIQ | 7'h03, 32'h0000_0003);
    @(negedge clk);
    check("R9 fiq drops", {31'b0, fiq}, 0);
    check("R9 irq stays", {31'b0, irq}, 1);
    wr_reg(7'h01, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R9 irq drops", {31'b0, irq}, 0);
    rd_reg(7'h04, got); check("R8 empty reads zero", got, 0);

    // R8 priority sweep: sources i..31 pending
    wr_reg(7'h02, 32'hFFFF_FFFF);
    wr_reg(FIQ | 7'h02, 32'hFFFF_0000);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] m;
      m = 32'hFFFF_FFFF << i;
      pulse(m);
      rd_reg(7'h04, got);       check("R8 irq lowest", got, num_word(m));
      rd_reg(FIQ | 7'h04, got); check("R8 fiq lowest", got, num_word(m & 32'hFFFF_0000));
      rd_reg(FIQ | 7'h00, got); check("R7 fiq masked sweep", got, m & 32'hFFFF_0000);
      wr_reg(FIQ | 7'h01, m);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule